// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block prepares the second operand of an integer ALU. It takes a register value and can shift or rotate it by an amount that comes either from a 5-bit field held in the instruction or from the low byte of a second register. It can also hand the operand on untouched. Alongside the shaped value it produces the shifter carry, which a flag stage uses as the new carry flag for move and logical operations.

The unit is pipelined by one register stage. A request is presented with `in_valid` high. One clock edge later the result, its carry and `out_valid` appear. Between requests the outputs keep their last values. Six operations are supported: logical left, logical right, arithmetic right, rotate right, a one-bit rotate right through the incoming carry, and pass-through. Instruction decode and the ALU itself are outside the block.

Top module: `sop_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `out_valid_o`, `result_o` and `carry_o` are all 0.
- R2: A request taken at a rising edge with `in_valid` high is presented on the outputs, with `out_valid_o` high, right after that edge. When `in_valid` is low, `out_valid_o` is low after the edge and `result_o` and `carry_o` keep their values.
- R3: When `amt_src_i` is 2 or 3 (bypass), the result equals the operand and the carry equals `carry_i`, whatever the shift type.
- R4: With `amt_src_i` = 0 (immediate, `imm_amt_i`) or 1 (register, `reg_amt_i`), a selected amount of 0 returns the operand unchanged with carry equal to `carry_i`. This applies to shift types 0 to 3.
- R5: Shift type 0 (logical left) by 1 to 31 fills with zeros. The carry is the last bit shifted out, which is operand bit 32-n. For example, 0x8000_0004 by 1 gives 0x0000_0008 with carry 1, and a shift by 3 multiplies by 8.
- R6: Shift type 1 (logical right) by n in 1 to 31 fills with zeros, with carry = operand bit n-1.
- R7: Shift type 2 (arithmetic right) by n in 1 to 31 fills with copies of bit 31, with carry = operand bit n-1.
- R8: Shift type 3 (rotate right) uses the amount modulo 32. For a nonzero amount the carry equals result bit 31, including when the amount is a nonzero multiple of 32, where the result is the operand.
- R9: Shift type 4 (rotate through carry) gives {`carry_i`, operand[31:1]} with carry = operand bit 0. The amount inputs are ignored.
- R10: Logical shifts by a register amount of exactly 32 give 0, with carry = bit 0 for left and bit 31 for right. Amounts from 33 to 255 give 0 with carry 0.
- R11: An arithmetic right shift by 32 or more sets every result bit and the carry to operand bit 31.
- R12: Shift types 5, 6 and 7 pass the operand through unchanged with carry = `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| operand_i | input | 32 | Value to be shaped |
| shift_type_i | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry, 5-7 pass |
| amt_src_i | input | 2 | 0 immediate amount, 1 register amount, 2/3 bypass |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| out_valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Shaped operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Directed vectors walk each shift type through the amounts where the carry source changes. These are 0, 1, a mid value, 31, 32, 33 and 255, and they separate the in-range carry bit from the exact-32 rule, the saturated zero and the sign fill. For rotation, amounts 8, 40 and 32 show whether the modulo is taken and where the carry comes from when the rotation lands back on the operand. The rotate-through-carry case is run with both carry values, and the bypass and unused encodings are run with shift fields that would otherwise change the value. Random operands and amounts then compare every type against a bench model that shifts one bit per step. Idle gaps between requests show whether the outputs hold.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [2:0] {
        SH_LSL  = 3'd0,
        SH_LSR  = 3'd1,
        SH_ASR  = 3'd2,
        SH_ROR  = 3'd3,
        SH_RCX  = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'd0,
        SRC_REG  = 2'd1,
        SRC_BYP0 = 2'd2,
        SRC_BYP1 = 2'd3
    } amt_src_e;

endpackage

// File: rtl/sop_amount_sel.sv
module sop_amount_sel #(
    parameter int IMM_W  = 5,
    parameter int RAMT_W = 8
) (
    input  logic [1:0]        src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [RAMT_W-1:0] reg_i,
    output logic [RAMT_W-1:0] amt_o,
    output logic              bypass_o
);
    import sop_pkg::*;

    always_comb begin
        amt_o    = '0;
        bypass_o = 1'b0;
        case (src_i)
            SRC_IMM: amt_o = RAMT_W'(imm_i);
            SRC_REG: amt_o = reg_i;
            default: bypass_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core #(
    parameter int W      = 32,
    parameter int RAMT_W = 8
) (
    input  logic [W-1:0]      x_i,
    input  logic              cin_i,
    input  logic [2:0]        kind_i,
    input  logic [RAMT_W-1:0] amt_i,
    input  logic              bypass_i,
    output logic [W-1:0]      res_o,
    output logic              cout_o
);
    import sop_pkg::*;

    localparam int ROT_W = $clog2(W) + 1;

    logic [W:0]        lsl_ext;
    logic [W:0]        lsr_ext;
    logic signed [W:0] asr_src;
    logic [W:0]        asr_ext;
    logic [ROT_W-1:0]  rot;
    logic [W-1:0]      rot_res;

    assign lsl_ext = {1'b0, x_i} << amt_i;
    assign lsr_ext = {x_i, 1'b0} >> amt_i;
    assign asr_src = $signed({x_i, 1'b0});
    assign asr_ext = asr_src >>> amt_i;
    assign rot     = ROT_W'(amt_i % RAMT_W'(W));

    for (genvar g = 0; g < W; g++) begin : g_rot
        assign rot_res[g] = x_i[(g + int'(rot)) % W];
    end

    always_comb begin
        res_o  = x_i;
        cout_o = cin_i;
        if (!bypass_i) begin
            case (kind_i)
                SH_LSL: if (amt_i != '0) begin
                    res_o  = lsl_ext[W-1:0];
                    cout_o = lsl_ext[W];
                end
                SH_LSR: if (amt_i != '0) begin
                    res_o  = lsr_ext[W:1];
                    cout_o = lsr_ext[0];
                end
                SH_ASR: if (amt_i != '0) begin
                    res_o  = asr_ext[W:1];
                    cout_o = asr_ext[0];
                end
                SH_ROR: if (amt_i != '0) begin
                    res_o  = rot_res;
                    cout_o = rot_res[W-1];
                end
                SH_RCX: begin
                    res_o  = {cin_i, x_i[W-1:1]};
                    cout_o = x_i[0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sop_unit.sv
module sop_unit #(
    parameter int W      = 32,
    parameter int IMM_W  = 5,
    parameter int RAMT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      operand_i,
    input  logic [2:0]        shift_type_i,
    input  logic [1:0]        amt_src_i,
    input  logic [IMM_W-1:0]  imm_amt_i,
    input  logic [RAMT_W-1:0] reg_amt_i,
    input  logic              carry_i,
    output logic              out_valid_o,
    output logic [W-1:0]      result_o,
    output logic              carry_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         c;
    } stage_t;

    stage_t            st_d, st_q;
    logic [RAMT_W-1:0] amt;
    logic              bypass;
    logic [W-1:0]      core_res;
    logic              core_c;

    sop_amount_sel #(.IMM_W(IMM_W), .RAMT_W(RAMT_W)) amt_i (
        .src_i    (amt_src_i),
        .imm_i    (imm_amt_i),
        .reg_i    (reg_amt_i),
        .amt_o    (amt),
        .bypass_o (bypass)
    );

    sop_shift_core #(.W(W), .RAMT_W(RAMT_W)) core_i (
        .x_i      (operand_i),
        .cin_i    (carry_i),
        .kind_i   (shift_type_i),
        .amt_i    (amt),
        .bypass_i (bypass),
        .res_o    (core_res),
        .cout_o   (core_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = core_res;
            st_d.c   = core_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign result_o    = st_q.res;
    assign carry_o     = st_q.c;
endmodule

// File: rtl/sop_unit_chk.sv
module sop_unit_chk #(
    parameter int W      = 32,
    parameter int IMM_W  = 5,
    parameter int RAMT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [W-1:0]      operand_i,
    input logic [2:0]        shift_type_i,
    input logic [1:0]        amt_src_i,
    input logic [IMM_W-1:0]  imm_amt_i,
    input logic [RAMT_W-1:0] reg_amt_i,
    input logic              carry_i,
    input logic              out_valid_o,
    input logic [W-1:0]      result_o,
    input logic              carry_o
);
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid_o);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid_o && $stable(result_o) && $stable(carry_o)));

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt_src_i[1]) |=>
        (result_o == $past(operand_i) && carry_o == $past(carry_i)));

    p_zero_reg_amt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt_src_i == 2'd1 && reg_amt_i == '0 && shift_type_i < 3'd4) |=>
        (result_o == $past(operand_i) && carry_o == $past(carry_i)));

    p_rcx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !amt_src_i[1] && shift_type_i == 3'd4) |=>
        (result_o == {$past(carry_i), $past(operand_i[W-1:1])} && carry_o == $past(operand_i[0])));

    p_logic_far_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt_src_i == 2'd1 && shift_type_i < 3'd2 && int'(reg_amt_i) > W) |=>
        (result_o == '0 && !carry_o));

    p_asr_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt_src_i == 2'd1 && shift_type_i == 3'd2 && int'(reg_amt_i) >= W) |=>
        (result_o == {W{$past(operand_i[W-1])}} && carry_o == $past(operand_i[W-1])));

    p_unused_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_type_i > 3'd4) |=>
        (result_o == $past(operand_i) && carry_o == $past(carry_i)));
endmodule

bind sop_unit sop_unit_chk #(.W(W), .IMM_W(IMM_W), .RAMT_W(RAMT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .operand_i    (operand_i),
    .shift_type_i (shift_type_i),
    .amt_src_i    (amt_src_i),
    .imm_amt_i    (imm_amt_i),
    .reg_amt_i    (reg_amt_i),
    .carry_i      (carry_i),
    .out_valid_o  (out_valid_o),
    .result_o     (result_o),
    .carry_o      (carry_o)
);

// File: tb/sop_unit_tb.sv
module sop_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand_i = '0;
    logic [2:0]  shift_type_i = '0;
    logic [1:0]  amt_src_i = '0;
    logic [4:0]  imm_amt_i = '0;
    logic [7:0]  reg_amt_i = '0;
    logic        carry_i = 1'b0;
    logic        out_valid_o;
    logic [31:0] result_o;
    logic        carry_o;

    int tests = 0;
    int fails = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [32:0] last_exp = '0;
    string       last_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand_i(operand_i),
        .shift_type_i(shift_type_i), .amt_src_i(amt_src_i), .imm_amt_i(imm_amt_i),
        .reg_amt_i(reg_amt_i), .carry_i(carry_i), .out_valid_o(out_valid_o),
        .result_o(result_o), .carry_o(carry_o)
    );

    // Bit-serial reference: one single-bit step per unit of amount.
    function automatic logic [32:0] model(logic [31:0] x, logic [2:0] k, logic [1:0] src,
                                          logic [4:0] ia, logic [7:0] ra, logic cin);
        logic [31:0] v = x;
        logic        c = cin;
        int          n = (src == 2'd0) ? int'(ia) : int'(ra);
        if (src[1] || k > 3'd4) return {x, cin};
        if (k == 3'd4) return {cin, x[31:1], x[0]};
        for (int s = 0; s < n; s++) begin
            case (k)
                3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {v, c};
    endfunction

    task automatic drive(input logic [31:0] x, input logic [2:0] k, input logic [1:0] src,
                         input logic [4:0] ia, input logic [7:0] ra, input logic cin,
                         input string tag);
        @(negedge clk);
        operand_i = x; shift_type_i = k; amt_src_i = src;
        imm_amt_i = ia; reg_amt_i = ra; carry_i = cin; in_valid = 1'b1;
        exp_q.push_back(model(x, k, src, ia, ra, cin));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand_i = $urandom; carry_i = ~carry_i;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (out_valid_o) begin
                logic [32:0] e;
                string t;
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R2: unexpected out_valid, got %h/%b expected none", result_o, carry_o);
                end else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    tests++;
                    if ({result_o, carry_o} !== e) begin
                        fails++;
                        $display("FAIL %s: got %h c=%b expected %h c=%b", t, result_o, carry_o, e[32:1], e[0]);
                    end
                    last_exp = e; last_tag = t;
                end
            end else if (exp_q.size() == 0) begin
                tests++;
                if ({result_o, carry_o} !== last_exp) begin
                    fails++;
                    $display("FAIL R2 hold: got %h c=%b expected %h c=%b", result_o, carry_o, last_exp[32:1], last_exp[0]);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (out_valid_o !== 1'b0 || result_o !== '0 || carry_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: got v=%b %h c=%b expected 0 0 0", out_valid_o, result_o, carry_o);
        end
        rst_n = 1'b1;
        idle(2);
        // R3 bypass
        drive(32'hDEAD_BEEF, 3'd0, 2'd2, 5'd7, 8'd9, 1'b1, "R3");
        drive(32'h1234_5678, 3'd2, 2'd3, 5'd3, 8'd40, 1'b0, "R3");
        // R4 zero amounts
        drive(32'hF000_000F, 3'd0, 2'd0, 5'd0, 8'd5, 1'b1, "R4");
        drive(32'hF000_000F, 3'd1, 2'd1, 5'd9, 8'd0, 1'b0, "R4");
        drive(32'h8000_0001, 3'd3, 2'd1, 5'd9, 8'd0, 1'b1, "R4");
        // R5 LSL
        drive(32'h8000_0004, 3'd0, 2'd0, 5'd1, 8'd0, 1'b0, "R5");
        drive(32'h0000_0005, 3'd0, 2'd0, 5'd3, 8'd0, 1'b1, "R5");
        drive(32'h0000_0001, 3'd0, 2'd1, 5'd0, 8'd31, 1'b0, "R5");
        idle(3);
        // R6 LSR, R7 ASR
        drive(32'h0000_00F0, 3'd1, 2'd0, 5'd5, 8'd0, 1'b0, "R6");
        drive(32'h8000_0000, 3'd1, 2'd1, 5'd0, 8'd31, 1'b0, "R6");
        drive(32'h8000_0018, 3'd2, 2'd0, 5'd4, 8'd0, 1'b0, "R7");
        drive(32'h7FFF_FFFF, 3'd2, 2'd1, 5'd0, 8'd31, 1'b0, "R7");
        // R8 rotate
        drive(32'h1234_5678, 3'd3, 2'd0, 5'd8, 8'd0, 1'b0, "R8");
        drive(32'h1234_5678, 3'd3, 2'd1, 5'd0, 8'd40, 1'b0, "R8");
        drive(32'h8000_0000, 3'd3, 2'd1, 5'd0, 8'd32, 1'b0, "R8");
        drive(32'h0000_0001, 3'd3, 2'd1, 5'd0, 8'd64, 1'b1, "R8");
        // R9 rotate through carry
        drive(32'h0000_0003, 3'd4, 2'd0, 5'd7, 8'd0, 1'b1, "R9");
        drive(32'h8000_0002, 3'd4, 2'd1, 5'd0, 8'd0, 1'b0, "R9");
        idle(1);
        // R10 logical far amounts
        drive(32'h0000_0001, 3'd0, 2'd1, 5'd0, 8'd32, 1'b0, "R10");
        drive(32'hFFFF_FFFF, 3'd0, 2'd1, 5'd0, 8'd33, 1'b1, "R10");
        drive(32'h8000_0000, 3'd1, 2'd1, 5'd0, 8'd32, 1'b0, "R10");
        drive(32'hFFFF_FFFF, 3'd1, 2'd1, 5'd0, 8'd200, 1'b1, "R10");
        // R11 arithmetic saturation
        drive(32'h8000_0000, 3'd2, 2'd1, 5'd0, 8'd32, 1'b0, "R11");
        drive(32'h8765_4321, 3'd2, 2'd1, 5'd0, 8'd255, 1'b0, "R11");
        drive(32'h7FFF_FFFF, 3'd2, 2'd1, 5'd0, 8'd100, 1'b1, "R11");
        // R12 unused kinds
        drive(32'hCAFE_F00D, 3'd5, 2'd0, 5'd4, 8'd0, 1'b1, "R12");
        drive(32'hCAFE_F00D, 3'd6, 2'd1, 5'd0, 8'd3, 1'b0, "R12");
        drive(32'hCAFE_F00D, 3'd7, 2'd1, 5'd0, 8'd40, 1'b1, "R12");
        idle(2);
        // Random sweep across all types and sources
        for (int i = 0; i < 120; i++) begin
            drive($urandom, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                  5'($urandom), 8'($urandom), 1'($urandom), "R5..R12 random");
            if (i % 9 == 0) idle(1);
        end
        idle(4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule